// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block

This block is the host-facing register file of a classic eight-offset serial port. A processor reaches it through a byte-wide access strobe with a three-bit offset. Writes and side-effecting reads take effect at the clock edge of the access, and read data is presented combinationally during the access cycle. Bit timing and baud generation are outside the block. Characters to transmit appear as a one-cycle valid pulse with a byte. Received characters arrive on a valid/ready byte port and queue in a receive buffer. That buffer holds either a single entry or a parameterised number of entries, and the FIFO-enable control selects between the two.

A prioritised interrupt identification code is derived from the enable mask and from four sources: overrun, pending receive data, a sticky transmit-ready flag and the modem-status delta bits. The level interrupt output is high whenever that code is anything other than "nothing pending". A loopback control diverts transmitted bytes into the receive buffer and discards bytes that arrive from outside. The modem status byte is supplied from outside as an input. A divisor latch holds its reset value, computed from the reference clock and default baud rate, until software changes it.

Top module: `uart_host_regs`

## Requirements
- R1: After reset LCR, IER and MCR read 0x00, IIR reads 0x01, LSR reads 0x60, irq is low, the divisor reads low byte 12 and high byte 0 (1843200/9600/16), and the receive buffer holds one entry.
- R2: While LCR bit 7 is 1, offset 0 and offset 1 access the divisor low and high bytes. Such writes neither transmit a byte nor change IER.
- R3: An IER write keeps bits 3:0 and reads back with bits 7:4 zero. The transmit-ready pending flag is set by a data-register write, and by an IER write that takes bit 1 from 0 to 1. Rewriting bit 1 as 1 leaves the flag alone.
- R4: A data write with MCR bit 4 clear emits the byte on tx_data with tx_valid for one cycle. With MCR bit 4 set it goes into the receive buffer instead, and if the buffer is full the LSR overrun bit (bit 1) is set.
- R5: An FCR (offset 2) write whose bit 0 differs from the current FIFO-enable state empties the buffer and sets its capacity to FIFO_DEPTH (bit 0 = 1) or 1 (bit 0 = 0). With bit 0 set, bit 1 also empties the buffer. A write that keeps bit 0 at 1 with bit 1 clear leaves the contents alone. IIR bits 7:6 read 11 while enabled.
- R6: IIR bits 3:0 give the highest-priority enabled reason, in this order: overrun with IER bit 2 gives 0x6; a non-empty buffer with IER bit 0 gives 0xC; transmit-ready pending with IER bit 1 gives 0x2; any of modem_in[3:0] with IER bit 3 gives 0x0; otherwise 0x1. irq is high exactly when the code is not 0x1.
- R7: Reading IIR while it reports 0x2 clears the transmit-ready pending flag. Reading it while it reports another code leaves the flag alone.
- R8: An LSR (offset 5) read returns bits 6 and 5 as 1, bit 0 as buffer non-empty and bit 1 as overrun, and then clears overrun.
- R9: MCR (offset 4) keeps bits 4:0. Writes to LSR and MSR have no effect. An MSR (offset 6) read returns modem_in.
- R10: Data-register reads pop bytes in arrival order. A read of an empty buffer returns 0xFF and removes nothing.
- R11: Outside loopback, rx_ready is low exactly when the buffer is full, and a byte offered while it is low is dropped. In loopback, rx_ready is high and offered bytes are discarded.
- R12: The scratch register (offset 7) reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data during a read access |
| tx_valid | output | 1 | One-cycle pulse carrying a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Incoming byte will be taken |
| modem_in | input | 8 | Modem status byte, delta bits in 3:0 |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the sticky transmit-ready flag. A design that fires on the enable level rather than its rising edge reports 0x2 again after a plain rewrite of IER. A design that clears the flag on any IIR read loses the request that hides behind a receive interrupt. Priority is exercised with overrun and receive data pending together, where a wrong order shows 0xC instead of 0x6. Capacity is probed at both depths: the dropped byte after one entry, the full-buffer rx_ready drop after sixteen, and an FCR rewrite that must not flush. Loopback is probed for the overrun, for discarded inbound bytes, and for the divisor writes that must not leak out as transmitted bytes.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
   localparam logic [2:0] OFF_DATA = 3'd0;
   localparam logic [2:0] OFF_IER  = 3'd1;
   localparam logic [2:0] OFF_IIR  = 3'd2;
   localparam logic [2:0] OFF_LCR  = 3'd3;
   localparam logic [2:0] OFF_MCR  = 3'd4;
   localparam logic [2:0] OFF_LSR  = 3'd5;
   localparam logic [2:0] OFF_MSR  = 3'd6;
   localparam logic [2:0] OFF_SCR  = 3'd7;

   localparam int EN_RX    = 0;
   localparam int EN_TX    = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;
   localparam int LCR_DLAB = 7;
   localparam int MCR_LOOP = 4;
   localparam int FCR_ON   = 0;
   localparam int FCR_RXCLR = 1;

   typedef enum logic [3:0] {
      IRQ_MODEM  = 4'h0,
      IRQ_NONE   = 4'h1,
      IRQ_TXRDY  = 4'h2,
      IRQ_LINE   = 4'h6,
      IRQ_RXDATA = 4'hC
   } irq_code_t;
endpackage

// File: rtl/uhr_rx_fifo.sv
module uhr_rx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          flush_deep,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uhr_rx_fifo: DEPTH must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("uhr_rx_fifo: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q, wp_nxt, rp_nxt;
   logic [CW-1:0] cnt_q, cap;
   logic          deep_q, push_ok, pop_ok;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nxt = wp_q + PW'(1);
         assign rp_nxt = rp_q + PW'(1);
      end else begin : g_mod
         assign wp_nxt = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
         assign rp_nxt = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      end
   endgenerate

   assign cap     = deep_q ? CW'(DEPTH) : CW'(1);
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == cap);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rp_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         cnt_q  <= '0;
         deep_q <= 1'b0;
      end else if (flush) begin
         wp_q   <= '0;
         rp_q   <= '0;
         cnt_q  <= '0;
         deep_q <= flush_deep;
      end else begin
         if (push_ok) wp_q <= wp_nxt;
         if (pop_ok)  rp_q <= rp_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wp_q] <= push_data;
   end
endmodule

// File: rtl/uhr_irq_sel.sv
module uhr_irq_sel
   import uhr_pkg::*;
(
   input  logic [3:0] enables,
   input  logic       overrun,
   input  logic       rx_avail,
   input  logic       tx_pend,
   input  logic       modem_delta,
   output irq_code_t  code
);
   always_comb begin
      if (overrun && enables[EN_LINE])           code = IRQ_LINE;
      else if (rx_avail && enables[EN_RX])       code = IRQ_RXDATA;
      else if (tx_pend && enables[EN_TX])        code = IRQ_TXRDY;
      else if (modem_delta && enables[EN_MODEM]) code = IRQ_MODEM;
      else                                       code = IRQ_NONE;
   end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
   import uhr_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int REF_CLK_HZ = 1843200,
   parameter int BAUD       = 9600
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_ready,
   input  logic [7:0] modem_in,
   output logic       irq
);
   localparam int         RESET_DIV = REF_CLK_HZ / BAUD / 16;
   localparam logic [15:0] DIV_INIT = 16'(RESET_DIV);

   generate
      if (BAUD < 1 || RESET_DIV < 1 || RESET_DIV > 65535) begin : g_bad_div
         $error("uart_host_regs: reset divisor out of range");
      end
   endgenerate

   logic [7:0] dll_q, dlh_q, lcr_q, scr_q;
   logic [3:0] ier_q;
   logic [4:0] mcr_q;
   logic       fifo_on_q, lsr_oe_q, thre_pend_q, tx_valid_q;
   logic [7:0] tx_data_q;

   logic       dlab, loop, acc_wr, acc_rd;
   logic       wr_dll, wr_dlh, wr_thr, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
   logic       rd_rbr, rd_iir, rd_lsr;
   logic       fifo_flush, fifo_push, fifo_pop, fifo_empty, fifo_full;
   logic [7:0] fifo_head, fifo_wdata;
   irq_code_t  irq_code;

   assign dlab   = lcr_q[LCR_DLAB];
   assign loop   = mcr_q[MCR_LOOP];
   assign acc_wr = bus_sel && bus_we;
   assign acc_rd = bus_sel && !bus_we;

   assign wr_dll = acc_wr && dlab && (bus_addr == OFF_DATA);
   assign wr_dlh = acc_wr && dlab && (bus_addr == OFF_IER);
   assign wr_thr = acc_wr && !dlab && (bus_addr == OFF_DATA);
   assign wr_ier = acc_wr && !dlab && (bus_addr == OFF_IER);
   assign wr_fcr = acc_wr && (bus_addr == OFF_IIR);
   assign wr_lcr = acc_wr && (bus_addr == OFF_LCR);
   assign wr_mcr = acc_wr && (bus_addr == OFF_MCR);
   assign wr_scr = acc_wr && (bus_addr == OFF_SCR);
   assign rd_rbr = acc_rd && !dlab && (bus_addr == OFF_DATA);
   assign rd_iir = acc_rd && (bus_addr == OFF_IIR);
   assign rd_lsr = acc_rd && (bus_addr == OFF_LSR);

   // buffer control: enable toggle or explicit clear while enabled
   assign fifo_flush = wr_fcr && ((bus_wdata[FCR_ON] != fifo_on_q) ||
                                  (bus_wdata[FCR_ON] && bus_wdata[FCR_RXCLR]));
   assign fifo_push  = loop ? wr_thr : rx_valid;
   assign fifo_wdata = loop ? bus_wdata : rx_data;
   assign fifo_pop   = rd_rbr;
   assign rx_ready   = loop || !fifo_full;

   uhr_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (fifo_flush),
      .flush_deep (bus_wdata[FCR_ON]),
      .push       (fifo_push),
      .push_data  (fifo_wdata),
      .pop        (fifo_pop),
      .head       (fifo_head),
      .empty      (fifo_empty),
      .full       (fifo_full)
   );

   uhr_irq_sel u_irq (
      .enables     (ier_q),
      .overrun     (lsr_oe_q),
      .rx_avail    (!fifo_empty),
      .tx_pend     (thre_pend_q),
      .modem_delta (|modem_in[3:0]),
      .code        (irq_code)
   );

   assign irq = (irq_code != IRQ_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dll_q       <= DIV_INIT[7:0];
         dlh_q       <= DIV_INIT[15:8];
         ier_q       <= '0;
         lcr_q       <= '0;
         mcr_q       <= '0;
         scr_q       <= '0;
         fifo_on_q   <= 1'b0;
         lsr_oe_q    <= 1'b0;
         thre_pend_q <= 1'b0;
         tx_valid_q  <= 1'b0;
         tx_data_q   <= '0;
      end else begin
         tx_valid_q <= 1'b0;
         if (wr_dll) dll_q <= bus_wdata;
         if (wr_dlh) dlh_q <= bus_wdata;
         if (wr_lcr) lcr_q <= bus_wdata;
         if (wr_mcr) mcr_q <= bus_wdata[4:0];
         if (wr_scr) scr_q <= bus_wdata;
         if (wr_fcr) fifo_on_q <= bus_wdata[FCR_ON];
         if (wr_ier) begin
            ier_q <= bus_wdata[3:0];
            if (!ier_q[EN_TX] && bus_wdata[EN_TX]) thre_pend_q <= 1'b1;
         end
         if (wr_thr) begin
            thre_pend_q <= 1'b1;
            if (loop) begin
               if (fifo_full) lsr_oe_q <= 1'b1;
            end else begin
               tx_valid_q <= 1'b1;
               tx_data_q  <= bus_wdata;
            end
         end
         if (rd_iir && (irq_code == IRQ_TXRDY)) thre_pend_q <= 1'b0;
         if (rd_lsr) lsr_oe_q <= 1'b0;
      end
   end

   assign tx_valid = tx_valid_q;
   assign tx_data  = tx_data_q;

   always_comb begin
      unique case (bus_addr)
         OFF_DATA: bus_rdata = dlab ? dll_q : (fifo_empty ? 8'hFF : fifo_head);
         OFF_IER:  bus_rdata = dlab ? dlh_q : {4'b0000, ier_q};
         OFF_IIR:  bus_rdata = {fifo_on_q, fifo_on_q, 2'b00, irq_code};
         OFF_LCR:  bus_rdata = lcr_q;
         OFF_MCR:  bus_rdata = {3'b000, mcr_q};
         OFF_LSR:  bus_rdata = {1'b0, 1'b1, 1'b1, 3'b000, lsr_oe_q, !fifo_empty};
         OFF_MSR:  bus_rdata = modem_in;
         OFF_SCR:  bus_rdata = scr_q;
         default:  bus_rdata = 8'hFF;
      endcase
   end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_we,
   input logic [2:0] bus_addr,
   input logic [7:0] bus_rdata,
   input logic       tx_valid,
   input logic       rx_ready,
   input logic       irq,
   input logic [7:0] lcr_q,
   input logic [4:0] mcr_q,
   input logic       lsr_oe_q,
   input logic       thre_pend_q,
   input logic       fifo_full,
   input logic [3:0] irq_code
);
   // R4
   tx_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_sel && bus_we && bus_addr == 3'd0 && !lcr_q[7] && !mcr_q[4]));

   // R8
   oe_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd5) |=> !lsr_oe_q);

   // R7
   pend_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd2 && irq_code == 4'h2) |=> !thre_pend_q);

   // R6
   irq_matches_iir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd2) |-> ((bus_rdata[3:0] == 4'h1) == !irq));

   // R11
   ready_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> (fifo_full && !mcr_q[4]));

   // R3
   ier_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd1 && !lcr_q[7]) |-> (bus_rdata[7:4] == 4'h0));
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_rdata   (bus_rdata),
   .tx_valid    (tx_valid),
   .rx_ready    (rx_ready),
   .irq         (irq),
   .lcr_q       (lcr_q),
   .mcr_q       (mcr_q),
   .lsr_oe_q    (lsr_oe_q),
   .thre_pend_q (thre_pend_q),
   .fifo_full   (fifo_full),
   .irq_code    (irq_code)
);

// File: tb/uart_host_regs_test.sv
module uart_host_regs_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_sel, bus_we;
   logic [2:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic [7:0] modem_in;
   logic       irq;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0] rd_exp_q[$];
   string      rd_tag_q[$];
   logic [7:0] tx_exp_q[$];
   string      tx_tag_q[$];

   always #4 clk = ~clk;

   uart_host_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_ready(rx_ready), .modem_in(modem_in), .irq(irq)
   );

   task automatic note(input bit ok, input string tag, input string what,
                       input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // monitor: compares reads and transmitted bytes against the scoreboard
   always @(negedge clk) begin
      logic [7:0] e;
      string      t;
      #3;
      if (rst_n) begin
         if (bus_sel && !bus_we) begin
            if (rd_exp_q.size() == 0) note(1'b0, "R0", "unexpected read", bus_rdata, 0);
            else begin
               e = rd_exp_q.pop_front();
               t = rd_tag_q.pop_front();
               note(bus_rdata == e, t, "read data", bus_rdata, e);
            end
         end
         if (tx_valid) begin
            if (tx_exp_q.size() == 0) note(1'b0, "R4", "unexpected tx byte", tx_data, 0);
            else begin
               e = tx_exp_q.pop_front();
               t = tx_tag_q.pop_front();
               note(tx_data == e, t, "tx byte", tx_data, e);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      rd_exp_q.push_back(exp);
      rd_tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic expect_tx(input logic [7:0] d, input string tag);
      tx_exp_q.push_back(d);
      tx_tag_q.push_back(tag);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      #1 note(irq == exp, tag, "irq", irq, exp);
   endtask

   task automatic chk_ready(input logic exp, input string tag);
      @(negedge clk);
      #1 note(rx_ready == exp, tag, "rx_ready", rx_ready, exp);
   endtask

   task automatic rx_send(input logic [7:0] d, input logic exp_ready, input string tag);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      #1 note(rx_ready == exp_ready, tag, "rx_ready on offer", rx_ready, exp_ready);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      note(1'b0, "R0", "watchdog expired", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      rx_valid = 1'b0; rx_data = '0; modem_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd3, 8'h00, "R1 LCR");
      rd(3'd1, 8'h00, "R1 IER");
      rd(3'd4, 8'h00, "R1 MCR");
      rd(3'd2, 8'h01, "R1 IIR");
      rd(3'd5, 8'h60, "R1 LSR");
      chk_irq(1'b0, "R1");
      wr(3'd3, 8'h80);
      rd(3'd0, 8'h0C, "R1 divisor low");
      rd(3'd1, 8'h00, "R1 divisor high");

      // R2 divisor access while LCR bit 7 is set
      wr(3'd0, 8'h34);
      wr(3'd1, 8'h12);
      rd(3'd0, 8'h34, "R2 divisor low");
      rd(3'd1, 8'h12, "R2 divisor high");
      rd(3'd3, 8'h80, "R2 LCR");
      wr(3'd3, 8'h03);
      rd(3'd3, 8'h03, "R2 LCR");
      rd(3'd1, 8'h00, "R2 IER untouched");

      // R4 normal transmit; R6 masked pending gives no interrupt
      expect_tx(8'h55, "R4 transmit");
      wr(3'd0, 8'h55);
      rd(3'd2, 8'h01, "R6 masked");
      chk_irq(1'b0, "R6 masked");

      // R3 mask and pending; R7 clear on IIR read
      wr(3'd1, 8'hF2);
      rd(3'd1, 8'h02, "R3 IER mask");
      chk_irq(1'b1, "R6 tx pending");
      rd(3'd2, 8'h02, "R7 IIR tx");
      rd(3'd2, 8'h01, "R7 cleared");
      chk_irq(1'b0, "R7");
      wr(3'd1, 8'h02);
      rd(3'd2, 8'h01, "R3 no edge");
      wr(3'd1, 8'h00);
      wr(3'd1, 8'h02);
      rd(3'd2, 8'h02, "R3 rising edge");

      // R12 scratch
      wr(3'd7, 8'h5A);
      rd(3'd7, 8'h5A, "R12 scratch");

      // R6 modem reason; R9 MSR read-only
      wr(3'd1, 8'h08);
      modem_in = 8'hB1;
      rd(3'd2, 8'h00, "R6 modem");
      chk_irq(1'b1, "R6 modem");
      rd(3'd6, 8'hB1, "R9 MSR");
      wr(3'd6, 8'h00);
      rd(3'd6, 8'hB1, "R9 MSR write ignored");
      modem_in = 8'h00;
      rd(3'd2, 8'h01, "R6 modem gone");

      // single-entry buffer: R11, R6 priority, R10, R8
      wr(3'd1, 8'h0F);
      rx_send(8'h11, 1'b1, "R11 accept");
      chk_ready(1'b0, "R11 full at one");
      rx_send(8'h12, 1'b0, "R11 refuse");
      rd(3'd2, 8'h0C, "R6 rx over tx");
      rd(3'd5, 8'h61, "R8 data ready");
      rd(3'd0, 8'h11, "R10 pop");
      rd(3'd0, 8'hFF, "R10 empty read");
      rd(3'd5, 8'h60, "R8 empty");
      rd(3'd2, 8'h02, "R7 tx behind rx kept");
      rd(3'd2, 8'h01, "R7 cleared");
      chk_irq(1'b0, "R6");

      // deep buffer: R5
      wr(3'd1, 8'h01);
      wr(3'd2, 8'hC1);
      rd(3'd2, 8'hC1, "R5 enabled");
      for (int i = 0; i < 16; i++) rx_send(8'(8'h20 + i), 1'b1, "R11 deep accept");
      rx_send(8'h99, 1'b0, "R11 deep full");
      rd(3'd2, 8'hCC, "R5 rx code");
      rd(3'd0, 8'h20, "R10 order first");
      rd(3'd0, 8'h21, "R10 order second");
      wr(3'd2, 8'hC3);
      rd(3'd5, 8'h60, "R5 rx clear");
      rd(3'd2, 8'hC1, "R5 after clear");
      rx_send(8'h40, 1'b1, "R11");
      rx_send(8'h41, 1'b1, "R11");
      rx_send(8'h42, 1'b1, "R11");
      wr(3'd2, 8'hC1);
      rd(3'd0, 8'h40, "R5 rewrite keeps data");
      wr(3'd2, 8'h00);
      rd(3'd5, 8'h60, "R5 disable flushes");
      rd(3'd2, 8'h01, "R5 disabled");
      rx_send(8'h50, 1'b1, "R5 depth one");
      rx_send(8'h51, 1'b0, "R5 depth one full");
      rd(3'd0, 8'h50, "R5 depth one data");
      rd(3'd0, 8'hFF, "R5 depth one empty");
      wr(3'd2, 8'h06);
      rd(3'd2, 8'h01, "R5 enable clear stores 0");

      // loopback: R9 mask, R4 overrun, R6 priority, R8 clear, R11 discard
      wr(3'd4, 8'hFF);
      rd(3'd4, 8'h1F, "R9 MCR mask");
      wr(3'd1, 8'h05);
      wr(3'd0, 8'hA5);
      rd(3'd2, 8'h0C, "R4 loopback push");
      wr(3'd0, 8'hB6);
      rd(3'd2, 8'h06, "R6 line over rx");
      wr(3'd5, 8'h00);
      rd(3'd5, 8'h63, "R9 LSR write ignored");
      rd(3'd5, 8'h61, "R8 overrun cleared");
      rd(3'd2, 8'h0C, "R8 after clear");
      rd(3'd0, 8'hA5, "R4 loopback data");
      rd(3'd0, 8'hFF, "R4 second byte dropped");
      rx_send(8'h77, 1'b1, "R11 loopback ready");
      rd(3'd5, 8'h60, "R11 loopback discard");
      chk_irq(1'b0, "R6 idle");
      wr(3'd4, 8'h00);
      rd(3'd4, 8'h00, "R9 MCR");
      expect_tx(8'h3C, "R4 transmit after loopback");
      wr(3'd0, 8'h3C);

      repeat (4) @(negedge clk);
      note(tx_exp_q.size() == 0, "R4", "missing tx bytes", tx_exp_q.size(), 0);
      note(rd_exp_q.size() == 0, "R10", "unchecked reads", rd_exp_q.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule